// File: doc/BRIEF.md
# Calendar Timekeeping Counter with Daylight-Saving Adjustment

This block keeps wall-clock time and calendar date as a set of eight byte-wide registers: seconds, minutes, hours, day of week, date, month, year within the century, and century. A one-cycle update pulse, normally issued once per second by a divider elsewhere, advances the count by one second. The carry ripples as far as it needs to go in that same cycle: seconds into minutes, minutes into hours, hours into the day, the month, the year and the century. Month lengths and leap years are handled inside the block.

Three control inputs set how the registers are read. A data-mode bit selects binary or two-digit BCD for every field. An hour-mode bit selects a 0 to 23 hour or a 12-hour hour with a PM flag. An enable turns on the spring-forward and fall-back daylight-saving transitions. The format bits only change how the stored bytes are read. They never rewrite the bytes, so software reloads all fields through the parallel load port after changing a format bit. A load has priority over a tick in the same cycle.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset, seconds, minutes, hours, year and century read 0x00, and day of week, date and month read 0x01.
- R2: In a cycle with tick_i high and load_i low, seconds advance by one. Seconds 59 wrap to 0 and advance minutes. Minutes 59 wrap to 0 and advance hours. With tick_i and load_i both low, no register changes.
- R3: bin_mode_i=1 encodes every field as a plain binary number. bin_mode_i=0 encodes it as BCD, with the tens digit in bits [7:4] and the units digit in bits [3:0].
- R4: hour24_i=1 gives hours 0 to 23. hour24_i=0 uses bit 7 as the PM flag (1 = PM) and bits [6:0] for the hour 12, 1 to 11. 11:59:59 AM is followed by 12:00:00 PM (0x8C binary, 0x92 BCD), and 11:59:59 PM by 12:00:00 AM.
- R5: Changing bin_mode_i or hour24_i does not alter any stored register value.
- R6: When 23:59:59 advances, the time becomes 00:00:00. Day of week steps 1 to 7 and wraps back to 1 (Sunday is 1), and the date advances.
- R7: Months 4, 6, 9 and 11 have 30 days. February has 29 days when the year value is divisible by 4 and 28 days otherwise. All other months have 31 days. The date wraps to 1 and the month advances after the last day.
- R8: December wraps to January and advances the year. Year 99 wraps to 0 and advances the century, and century 99 wraps to 0.
- R9: With dst_en_i=1, on a Sunday (day of week 1) in month 4 with date 1 to 7, 1:59:59 AM is followed by 3:00:00 AM.
- R10: With dst_en_i=1, on a Sunday in month 10 with date 25 to 31, the first 1:59:59 AM is followed by 1:00:00 AM. The repeated hour then proceeds to 2:00:00. A load or the next midnight re-arms the adjustment.
- R11: With dst_en_i=0, 1:59:59 is always followed by 2:00:00.
- R12: With load_i high, every register takes its load value on that edge regardless of tick_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second update pulse, one cycle wide |
| load_i | input | 1 | Parallel load strobe for all registers |
| bin_mode_i | input | 1 | 1 = binary fields, 0 = BCD fields |
| hour24_i | input | 1 | 1 = 24-hour hours, 0 = 12-hour with PM flag |
| dst_en_i | input | 1 | Daylight-saving transitions enabled |
| load_sec_i | input | 8 | Seconds load value |
| load_min_i | input | 8 | Minutes load value |
| load_hour_i | input | 8 | Hours load value |
| load_dow_i | input | 8 | Day-of-week load value |
| load_date_i | input | 8 | Date load value |
| load_mon_i | input | 8 | Month load value |
| load_year_i | input | 8 | Year load value |
| load_cent_i | input | 8 | Century load value |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours |
| dow_o | output | 8 | Day of week |
| date_o | output | 8 | Date of month |
| mon_o | output | 8 | Month |
| year_o | output | 8 | Year within century |
| cent_o | output | 8 | Century |

## Verification
Every register result, including a carry that ripples from seconds through to the century and both daylight-saving jumps, appears one clock after the edge that samples tick_i or load_i. There is no further pipeline delay. The bench changes inputs only on falling edges. A behavioural model advances on the same rising edge as the design, and all eight outputs are compared with the model at the next falling edge. Directed checks read their expected literal values at that same falling edge, after the stated number of ticks.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int FW = 8;
  typedef logic [FW-1:0] field_t;

  // decode a stored field to a plain integer
  function automatic int fld_dec(field_t v, logic bin);
    if (bin) return int'(v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  // encode a plain integer (0..99) as a stored field
  function automatic field_t fld_enc(int n, logic bin);
    field_t r;
    if (bin) r = field_t'(n);
    else     r = {4'(n / 10), 4'(n % 10)};
    return r;
  endfunction

  // stored hour -> 0..23
  function automatic int hr_to24(field_t v, logic bin, logic h24);
    int h;
    if (h24) return fld_dec(v, bin);
    h = fld_dec({1'b0, v[6:0]}, bin);
    if (h == 12) h = 0;
    if (v[7]) h = h + 12;
    return h;
  endfunction

  // 0..23 -> stored hour
  function automatic field_t hr_from24(int h, logic bin, logic h24);
    int r;
    if (h24) return fld_enc(h, bin);
    r = h % 12;
    if (r == 0) r = 12;
    return fld_enc(r, bin) | ((h >= 12) ? field_t'(8'h80) : field_t'(8'h00));
  endfunction

  function automatic logic year_is_leap(int y, int div);
    return (y % div) == 0;
  endfunction

  function automatic int month_len(int m, logic leap);
    case (m)
      2:             return leap ? 29 : 28;
      4, 6, 9, 11:   return 30;
      default:       return 31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_cal_dst_detect.sv
module rtc_cal_dst_detect
  import rtc_cal_pkg::*;
#(
  parameter int SEC_LAST        = 59,
  parameter int MIN_LAST        = 59,
  parameter int DST_HOUR        = 1,
  parameter int SUNDAY          = 1,
  parameter int SPRING_MON      = 4,
  parameter int SPRING_DATE_MAX = 7,
  parameter int FALL_MON        = 10,
  parameter int FALL_DATE_MIN   = 25
) (
  input  logic   dst_en_i,
  input  logic   bin_i,
  input  logic   h24_i,
  input  logic   fall_done_i,
  input  field_t sec_i,
  input  field_t min_i,
  input  field_t hour_i,
  input  field_t dow_i,
  input  field_t date_i,
  input  field_t mon_i,
  output logic   spring_hit_o,
  output logic   fall_hit_o
);
  logic at_edge;
  int   mon_v;
  int   date_v;

  assign mon_v  = fld_dec(mon_i, bin_i);
  assign date_v = fld_dec(date_i, bin_i);

  // last second of the switching hour on a Sunday
  assign at_edge = dst_en_i
                && (fld_dec(sec_i, bin_i) == SEC_LAST)
                && (fld_dec(min_i, bin_i) == MIN_LAST)
                && (hr_to24(hour_i, bin_i, h24_i) == DST_HOUR)
                && (fld_dec(dow_i, bin_i) == SUNDAY);

  assign spring_hit_o = at_edge && (mon_v == SPRING_MON) && (date_v <= SPRING_DATE_MAX);
  assign fall_hit_o   = at_edge && (mon_v == FALL_MON) && (date_v >= FALL_DATE_MIN)
                     && !fall_done_i;
endmodule

// File: rtl/rtc_cal_clock.sv
module rtc_cal_clock
  import rtc_cal_pkg::*;
#(
  parameter int SEC_LAST  = 59,
  parameter int MIN_LAST  = 59,
  parameter int HOUR_LAST = 23,
  parameter int DST_HOUR  = 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick_i,
  input  logic   load_i,
  input  logic   bin_i,
  input  logic   h24_i,
  input  field_t ld_sec_i,
  input  field_t ld_min_i,
  input  field_t ld_hour_i,
  input  logic   spring_hit_i,
  input  logic   fall_hit_i,
  output field_t sec_o,
  output field_t min_o,
  output field_t hour_o,
  output logic   fall_done_o,
  output logic   sec_wrap_o,
  output logic   day_carry_o,
  output logic   spring_evt_o,
  output logic   fall_evt_o
);
  localparam int SPRING_TARGET = DST_HOUR + 2;

  field_t sec_q, min_q, hour_q;
  field_t sec_d, min_d, hour_d;
  logic   fdone_q, fdone_d;
  int     s_cur, m_cur, h_cur;

  always_comb begin
    s_cur = fld_dec(sec_q, bin_i);
    m_cur = fld_dec(min_q, bin_i);
    h_cur = hr_to24(hour_q, bin_i, h24_i);
    sec_d = sec_q;
    min_d = min_q;
    hour_d = hour_q;
    fdone_d = fdone_q;
    sec_wrap_o = 1'b0;
    day_carry_o = 1'b0;
    spring_evt_o = 1'b0;
    fall_evt_o = 1'b0;
    if (load_i) begin
      sec_d = ld_sec_i;
      min_d = ld_min_i;
      hour_d = ld_hour_i;
      fdone_d = 1'b0;
    end else if (tick_i) begin
      if (s_cur >= SEC_LAST) begin
        sec_d = fld_enc(0, bin_i);
        sec_wrap_o = 1'b1;
        if (m_cur >= MIN_LAST) begin
          min_d = fld_enc(0, bin_i);
          if (spring_hit_i) begin
            hour_d = hr_from24(SPRING_TARGET, bin_i, h24_i);
            spring_evt_o = 1'b1;
          end else if (fall_hit_i) begin
            hour_d = hr_from24(DST_HOUR, bin_i, h24_i);
            fdone_d = 1'b1;
            fall_evt_o = 1'b1;
          end else if (h_cur >= HOUR_LAST) begin
            hour_d = hr_from24(0, bin_i, h24_i);
            fdone_d = 1'b0;
            day_carry_o = 1'b1;
          end else begin
            hour_d = hr_from24(h_cur + 1, bin_i, h24_i);
          end
        end else begin
          min_d = fld_enc(m_cur + 1, bin_i);
        end
      end else begin
        sec_d = fld_enc(s_cur + 1, bin_i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q   <= '0;
      min_q   <= '0;
      hour_q  <= '0;
      fdone_q <= 1'b0;
    end else begin
      sec_q   <= sec_d;
      min_q   <= min_d;
      hour_q  <= hour_d;
      fdone_q <= fdone_d;
    end
  end

  assign sec_o = sec_q;
  assign min_o = min_q;
  assign hour_o = hour_q;
  assign fall_done_o = fdone_q;
endmodule

// File: rtl/rtc_cal_date.sv
module rtc_cal_date
  import rtc_cal_pkg::*;
#(
  parameter int DOW_LAST  = 7,
  parameter int MON_LAST  = 12,
  parameter int YEAR_LAST = 99,
  parameter int LEAP_DIV  = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_i,
  input  logic   bin_i,
  input  logic   day_carry_i,
  input  field_t ld_dow_i,
  input  field_t ld_date_i,
  input  field_t ld_mon_i,
  input  field_t ld_year_i,
  input  field_t ld_cent_i,
  output field_t dow_o,
  output field_t date_o,
  output field_t mon_o,
  output field_t year_o,
  output field_t cent_o,
  output logic   year_carry_o
);
  localparam field_t ONE = field_t'(1);

  field_t dow_q, date_q, mon_q, year_q, cent_q;
  field_t dow_d, date_d, mon_d, year_d, cent_d;
  int     dw, dt, mo, yr, ce;

  always_comb begin
    dw = fld_dec(dow_q, bin_i);
    dt = fld_dec(date_q, bin_i);
    mo = fld_dec(mon_q, bin_i);
    yr = fld_dec(year_q, bin_i);
    ce = fld_dec(cent_q, bin_i);
    dow_d = dow_q;
    date_d = date_q;
    mon_d = mon_q;
    year_d = year_q;
    cent_d = cent_q;
    year_carry_o = 1'b0;
    if (load_i) begin
      dow_d = ld_dow_i;
      date_d = ld_date_i;
      mon_d = ld_mon_i;
      year_d = ld_year_i;
      cent_d = ld_cent_i;
    end else if (day_carry_i) begin
      dow_d = (dw >= DOW_LAST) ? fld_enc(1, bin_i) : fld_enc(dw + 1, bin_i);
      if (dt >= month_len(mo, year_is_leap(yr, LEAP_DIV))) begin
        date_d = fld_enc(1, bin_i);
        if (mo >= MON_LAST) begin
          mon_d = fld_enc(1, bin_i);
          year_carry_o = 1'b1;
          if (yr >= YEAR_LAST) begin
            year_d = fld_enc(0, bin_i);
            cent_d = (ce >= YEAR_LAST) ? fld_enc(0, bin_i) : fld_enc(ce + 1, bin_i);
          end else begin
            year_d = fld_enc(yr + 1, bin_i);
          end
        end else begin
          mon_d = fld_enc(mo + 1, bin_i);
        end
      end else begin
        date_d = fld_enc(dt + 1, bin_i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dow_q  <= ONE;
      date_q <= ONE;
      mon_q  <= ONE;
      year_q <= '0;
      cent_q <= '0;
    end else begin
      dow_q  <= dow_d;
      date_q <= date_d;
      mon_q  <= mon_d;
      year_q <= year_d;
      cent_q <= cent_d;
    end
  end

  assign dow_o = dow_q;
  assign date_o = date_q;
  assign mon_o = mon_q;
  assign year_o = year_q;
  assign cent_o = cent_q;
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int SEC_LAST        = 59,
  parameter int MIN_LAST        = 59,
  parameter int HOUR_LAST       = 23,
  parameter int DOW_LAST        = 7,
  parameter int MON_LAST        = 12,
  parameter int YEAR_LAST       = 99,
  parameter int LEAP_DIV        = 4,
  parameter int DST_HOUR        = 1,
  parameter int SUNDAY          = 1,
  parameter int SPRING_MON      = 4,
  parameter int SPRING_DATE_MAX = 7,
  parameter int FALL_MON        = 10,
  parameter int FALL_DATE_MIN   = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       load_i,
  input  logic       bin_mode_i,
  input  logic       hour24_i,
  input  logic       dst_en_i,
  input  logic [7:0] load_sec_i,
  input  logic [7:0] load_min_i,
  input  logic [7:0] load_hour_i,
  input  logic [7:0] load_dow_i,
  input  logic [7:0] load_date_i,
  input  logic [7:0] load_mon_i,
  input  logic [7:0] load_year_i,
  input  logic [7:0] load_cent_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o,
  output logic [7:0] cent_o
);
  // named internal events, observed by the bound checker
  logic spring_hit, fall_hit, fall_done;
  logic sec_wrap, day_carry, spring_evt, fall_evt, year_carry;

  rtc_cal_dst_detect #(
    .SEC_LAST(SEC_LAST), .MIN_LAST(MIN_LAST), .DST_HOUR(DST_HOUR), .SUNDAY(SUNDAY),
    .SPRING_MON(SPRING_MON), .SPRING_DATE_MAX(SPRING_DATE_MAX),
    .FALL_MON(FALL_MON), .FALL_DATE_MIN(FALL_DATE_MIN)
  ) u_dst (
    .dst_en_i(dst_en_i), .bin_i(bin_mode_i), .h24_i(hour24_i), .fall_done_i(fall_done),
    .sec_i(sec_o), .min_i(min_o), .hour_i(hour_o), .dow_i(dow_o),
    .date_i(date_o), .mon_i(mon_o),
    .spring_hit_o(spring_hit), .fall_hit_o(fall_hit)
  );

  rtc_cal_clock #(
    .SEC_LAST(SEC_LAST), .MIN_LAST(MIN_LAST), .HOUR_LAST(HOUR_LAST), .DST_HOUR(DST_HOUR)
  ) u_clock (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .load_i(load_i),
    .bin_i(bin_mode_i), .h24_i(hour24_i),
    .ld_sec_i(load_sec_i), .ld_min_i(load_min_i), .ld_hour_i(load_hour_i),
    .spring_hit_i(spring_hit), .fall_hit_i(fall_hit),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .fall_done_o(fall_done),
    .sec_wrap_o(sec_wrap), .day_carry_o(day_carry),
    .spring_evt_o(spring_evt), .fall_evt_o(fall_evt)
  );

  rtc_cal_date #(
    .DOW_LAST(DOW_LAST), .MON_LAST(MON_LAST), .YEAR_LAST(YEAR_LAST), .LEAP_DIV(LEAP_DIV)
  ) u_date (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .bin_i(bin_mode_i), .day_carry_i(day_carry),
    .ld_dow_i(load_dow_i), .ld_date_i(load_date_i), .ld_mon_i(load_mon_i),
    .ld_year_i(load_year_i), .ld_cent_i(load_cent_i),
    .dow_o(dow_o), .date_o(date_o), .mon_o(mon_o), .year_o(year_o), .cent_o(cent_o),
    .year_carry_o(year_carry)
  );
endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic       load_i,
  input logic       dst_en_i,
  input logic [7:0] load_sec_i,
  input logic [7:0] load_hour_i,
  input logic [7:0] load_cent_i,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] dow_o,
  input logic [7:0] date_o,
  input logic [7:0] mon_o,
  input logic [7:0] year_o,
  input logic [7:0] cent_o,
  input logic       sec_wrap,
  input logic       day_carry,
  input logic       spring_evt,
  input logic       fall_evt,
  input logic       year_carry
);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o)
      && $stable(dow_o) && $stable(date_o) && $stable(mon_o) && $stable(year_o)
      && $stable(cent_o)));

  a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wrap |=> (sec_o == 8'h00));

  a_r12_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> ((sec_o == $past(load_sec_i)) && (hour_o == $past(load_hour_i))
      && (cent_o == $past(load_cent_i))));

  a_r6_day_step: assert property (@(posedge clk) disable iff (!rst_n)
    day_carry |=> ((sec_o == 8'h00) && (min_o == 8'h00) && (dow_o != $past(dow_o))));

  a_r8_new_year: assert property (@(posedge clk) disable iff (!rst_n)
    year_carry |=> ((mon_o == 8'h01) && (date_o == 8'h01)));

  a_r9_spring_hour: assert property (@(posedge clk) disable iff (!rst_n)
    spring_evt |=> ((hour_o == 8'h03) && (min_o == 8'h00)));

  a_r10_fall_hour: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> ((hour_o == 8'h01) && (min_o == 8'h00)));

  a_r11_dst_off: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_en_i |-> (!spring_evt && !fall_evt));

  a_r9_one_jump: assert property (@(posedge clk) disable iff (!rst_n)
    !(spring_evt && fall_evt));
endmodule

bind rtc_calendar_core rtc_calendar_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .load_i(load_i), .dst_en_i(dst_en_i),
  .load_sec_i(load_sec_i), .load_hour_i(load_hour_i), .load_cent_i(load_cent_i),
  .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o), .date_o(date_o),
  .mon_o(mon_o), .year_o(year_o), .cent_o(cent_o),
  .sec_wrap(sec_wrap), .day_carry(day_carry), .spring_evt(spring_evt),
  .fall_evt(fall_evt), .year_carry(year_carry)
);

// File: tb/rtc_calendar_core_tb.sv
module rtc_calendar_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0, load_i = 1'b0;
  logic bin_mode_i = 1'b0, hour24_i = 1'b1, dst_en_i = 1'b0;
  logic [7:0] load_sec_i = '0, load_min_i = '0, load_hour_i = '0, load_dow_i = '0;
  logic [7:0] load_date_i = '0, load_mon_i = '0, load_year_i = '0, load_cent_i = '0;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, mon_o, year_o, cent_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rtc_calendar_core u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .load_i(load_i),
    .bin_mode_i(bin_mode_i), .hour24_i(hour24_i), .dst_en_i(dst_en_i),
    .load_sec_i(load_sec_i), .load_min_i(load_min_i), .load_hour_i(load_hour_i),
    .load_dow_i(load_dow_i), .load_date_i(load_date_i), .load_mon_i(load_mon_i),
    .load_year_i(load_year_i), .load_cent_i(load_cent_i),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
    .date_o(date_o), .mon_o(mon_o), .year_o(year_o), .cent_o(cent_o)
  );

  // ---------------- reference model ----------------
  function automatic int dec(logic [7:0] v, bit b);
    return b ? int'(v) : (int'(v) / 16) * 10 + int'(v) % 16;
  endfunction
  function automatic logic [7:0] enc(int n, bit b);
    return b ? 8'(n) : 8'((n / 10) * 16 + n % 10);
  endfunction
  function automatic int hdec(logic [7:0] v, bit b, bit t24);
    if (t24) return dec(v, b);
    return dec(v & 8'h7F, b) % 12 + (v[7] ? 12 : 0);
  endfunction
  function automatic logic [7:0] henc(int h, bit b, bit t24);
    if (t24) return enc(h, b);
    return ((h >= 12) ? 8'h80 : 8'h00) | enc((h + 11) % 12 + 1, b);
  endfunction
  function automatic int mdays(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  logic [7:0] m_sec, m_min, m_hour, m_dow, m_date, m_mon, m_year, m_cent;
  bit m_fd;
  int s, mi, h, dw, dt, mo, yr, ce;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hour = 0; m_dow = 1; m_date = 1; m_mon = 1;
      m_year = 0; m_cent = 0; m_fd = 0;
    end else if (load_i) begin
      m_sec = load_sec_i; m_min = load_min_i; m_hour = load_hour_i; m_dow = load_dow_i;
      m_date = load_date_i; m_mon = load_mon_i; m_year = load_year_i; m_cent = load_cent_i;
      m_fd = 0;
    end else if (tick_i) begin
      s = dec(m_sec, bin_mode_i); mi = dec(m_min, bin_mode_i);
      h = hdec(m_hour, bin_mode_i, hour24_i); dw = dec(m_dow, bin_mode_i);
      dt = dec(m_date, bin_mode_i); mo = dec(m_mon, bin_mode_i);
      yr = dec(m_year, bin_mode_i); ce = dec(m_cent, bin_mode_i);
      s = s + 1;
      if (s == 60) begin
        s = 0; mi = mi + 1;
        if (mi == 60) begin
          mi = 0;
          if (dst_en_i && mo == 4 && dw == 1 && dt <= 7 && h == 1) h = 3;
          else if (dst_en_i && mo == 10 && dw == 1 && dt >= 25 && h == 1 && !m_fd) m_fd = 1;
          else begin
            h = h + 1;
            if (h == 24) begin
              h = 0; m_fd = 0; dw = dw % 7 + 1; dt = dt + 1;
              if (dt > mdays(mo, yr)) begin
                dt = 1; mo = mo + 1;
                if (mo == 13) begin
                  mo = 1; yr = yr + 1;
                  if (yr == 100) begin yr = 0; ce = (ce + 1) % 100; end
                end
              end
            end
          end
        end
      end
      m_sec = enc(s, bin_mode_i); m_min = enc(mi, bin_mode_i);
      m_hour = henc(h, bin_mode_i, hour24_i); m_dow = enc(dw, bin_mode_i);
      m_date = enc(dt, bin_mode_i); m_mon = enc(mo, bin_mode_i);
      m_year = enc(yr, bin_mode_i); m_cent = enc(ce, bin_mode_i);
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare with the model on every falling edge
  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      chk("R2 seconds vs model", sec_o, m_sec);
      chk("R2 minutes vs model", min_o, m_min);
      chk("R4 hours vs model", hour_o, m_hour);
      chk("R6 day-of-week vs model", dow_o, m_dow);
      chk("R7 date vs model", date_o, m_date);
      chk("R7 month vs model", mon_o, m_mon);
      chk("R8 year vs model", year_o, m_year);
      chk("R8 century vs model", cent_o, m_cent);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic ld(bit b, bit t24, bit d, logic [7:0] vs, logic [7:0] vm, logic [7:0] vh,
                    logic [7:0] vw, logic [7:0] vd, logic [7:0] vo, logic [7:0] vy,
                    logic [7:0] vc);
    bin_mode_i = b; hour24_i = t24; dst_en_i = d;
    load_sec_i = vs; load_min_i = vm; load_hour_i = vh; load_dow_i = vw;
    load_date_i = vd; load_mon_i = vo; load_year_i = vy; load_cent_i = vc;
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic run(int n);
    tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset sec", sec_o, 8'h00);
    chk("R1 reset hour", hour_o, 8'h00);
    chk("R1 reset dow", dow_o, 8'h01);
    chk("R1 reset date", date_o, 8'h01);
    chk("R1 reset month", mon_o, 8'h01);
    chk("R1 reset century", cent_o, 8'h00);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    @(negedge clk);

    // R6 R8 BCD 24h: Fri 31 Dec 1999 23:59:58 -> Sat 1 Jan 2000
    ld(0, 1, 0, 8'h58, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99, 8'h19);
    run(2);
    chk("R6 midnight hour", hour_o, 8'h00);
    chk("R6 dow step", dow_o, 8'h07);
    chk("R8 month wrap", mon_o, 8'h01);
    chk("R8 year wrap", year_o, 8'h00);
    chk("R8 century step", cent_o, 8'h20);
    run(1);
    chk("R3 BCD seconds", sec_o, 8'h01);
    repeat (3) @(negedge clk);
    chk("R2 hold without tick", sec_o, 8'h01);
    run(1);
    chk("R6 sunday wrap", dow_o, 8'h07);

    // R4 binary 12h: Sat 30 Jun, 11:59:59 PM -> Sun 1 Jul 12 AM
    ld(1, 0, 0, 8'd59, 8'd59, 8'h8B, 8'd7, 8'd30, 8'd6, 8'd5, 8'd20);
    run(1);
    chk("R4 12 AM", hour_o, 8'h0C);
    chk("R6 dow wrap to 1", dow_o, 8'h01);
    chk("R7 30-day month", mon_o, 8'd7);
    ld(1, 0, 0, 8'd59, 8'd59, 8'h0B, 8'd3, 8'd10, 8'd3, 8'd5, 8'd20);
    run(1);
    chk("R4 noon binary", hour_o, 8'h8C);
    ld(0, 0, 0, 8'h59, 8'h59, 8'h11, 8'h03, 8'h10, 8'h03, 8'h05, 8'h20);
    run(1);
    chk("R4 noon BCD", hour_o, 8'h92);
    ld(1, 0, 0, 8'd59, 8'd59, 8'h0C, 8'd3, 8'd10, 8'd3, 8'd5, 8'd20);
    run(1);
    chk("R4 12 AM to 1 AM", hour_o, 8'h01);

    // R7 leap years, BCD 24h
    ld(0, 1, 0, 8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24, 8'h20);
    run(1);
    chk("R7 leap Feb 29", date_o, 8'h29);
    ld(0, 1, 0, 8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h20);
    run(1);
    chk("R7 common Feb end", mon_o, 8'h03);
    ld(0, 1, 0, 8'h59, 8'h59, 8'h23, 8'h02, 8'h29, 8'h02, 8'h00, 8'h21);
    run(1);
    chk("R7 leap year 00", date_o, 8'h01);

    // R9 spring forward
    ld(0, 1, 1, 8'h59, 8'h59, 8'h01, 8'h01, 8'h07, 8'h04, 8'h26, 8'h20);
    run(1);
    chk("R9 spring to 3", hour_o, 8'h03);
    ld(1, 0, 1, 8'd59, 8'd59, 8'h01, 8'd1, 8'd1, 8'd4, 8'd26, 8'd20);
    run(1);
    chk("R9 spring 12h binary", hour_o, 8'h03);
    ld(0, 1, 1, 8'h59, 8'h59, 8'h01, 8'h01, 8'h08, 8'h04, 8'h26, 8'h20);
    run(1);
    chk("R9 not first week", hour_o, 8'h02);
    ld(0, 1, 0, 8'h59, 8'h59, 8'h01, 8'h01, 8'h07, 8'h04, 8'h26, 8'h20);
    run(1);
    chk("R11 spring disabled", hour_o, 8'h02);

    // R10 fall back, once
    ld(0, 1, 1, 8'h59, 8'h59, 8'h01, 8'h01, 8'h25, 8'h10, 8'h26, 8'h20);
    run(1);
    chk("R10 fall to 1", hour_o, 8'h01);
    run(3599);
    chk("R10 repeated hour end", min_o, 8'h59);
    run(1);
    chk("R10 second pass to 2", hour_o, 8'h02);
    ld(0, 1, 0, 8'h59, 8'h59, 8'h01, 8'h01, 8'h31, 8'h10, 8'h26, 8'h20);
    run(1);
    chk("R11 fall disabled", hour_o, 8'h02);

    // R5 format change leaves values alone
    ld(0, 1, 0, 8'h45, 8'h30, 8'h21, 8'h02, 8'h15, 8'h05, 8'h26, 8'h20);
    bin_mode_i = 1'b1; hour24_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 seconds unchanged", sec_o, 8'h45);
    chk("R5 hour unchanged", hour_o, 8'h21);
    bin_mode_i = 1'b0; hour24_i = 1'b1;

    // R12 load beats tick
    tick_i = 1'b1;
    ld(0, 1, 0, 8'h10, 8'h20, 8'h05, 8'h03, 8'h11, 8'h08, 8'h30, 8'h20);
    tick_i = 1'b0;
    chk("R12 load over tick", sec_o, 8'h10);

    // randomized corner loads, compared with the model each cycle
    for (int i = 0; i < 300; i++) begin
      bit b, t, d;
      int kind, rmo, rdt, rdw, ryr, rce, rh, rs;
      b = 1'($urandom_range(0, 1)); t = 1'($urandom_range(0, 1));
      d = 1'($urandom_range(0, 1)); kind = $urandom_range(0, 3);
      rmo = $urandom_range(1, 12); ryr = $urandom_range(0, 99);
      rce = $urandom_range(19, 99); rdw = $urandom_range(1, 7);
      rdt = $urandom_range(1, mdays(rmo, ryr)); rh = 23; rs = $urandom_range(52, 59);
      if (kind == 1) begin rmo = 4; rdw = 1; rdt = $urandom_range(1, 10); rh = 1; end
      if (kind == 2) begin rmo = 10; rdw = 1; rdt = $urandom_range(20, 31); rh = 1; end
      if (kind == 3) rdt = mdays(rmo, ryr);
      if (kind == 3 && $urandom_range(0, 1) == 1) rmo = 12;
      if (kind == 3) rdt = mdays(rmo, ryr);
      ld(b, t, d, enc(rs, b), enc(59, b), henc(rh, b, t), enc(rdw, b), enc(rdt, b),
         enc(rmo, b), enc(ryr, b), enc(rce, b));
      run($urandom_range(3, 10));
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule